// File: doc/BRIEF.md
# Receive-Only Two-Wire Bus Slave Front End

This block is the bit-level receiver of a write-only device on a two-wire serial bus. A system clock samples the open-drain clock and data lines. Each line passes through a two-stage synchronizer and a stable-count filter, and the filter drops pulses shorter than a parameterised glitch width. The block then finds start, repeated start and stop conditions and shifts bytes in most significant bit first. It compares the first byte of each transfer with its own seven-bit address plus a write bit. While it is addressed, it pulls the data line low through an output enable during every ninth clock.

Downstream logic gets a one-cycle byte strobe with the byte value and its position after the address byte. It also gets one-cycle pulses for start, repeated start and stop. The stop pulse fires only when this device was addressed in the transfer that the stop ends, so downstream logic can use it as a commit point.

The sequencer has six states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK drives the acknowledge for the address. DATA shifts in a data byte. DATA_ACK drives the acknowledge for that byte. IGNORE waits out a transfer meant for another device. The transitions are as follows. A start in any state goes to ADDR. A stop in any state goes to IDLE. ADDR goes to ADDR_ACK on the falling clock edge after eight bits if the byte matches, and to IGNORE if it does not. ADDR_ACK goes to DATA on the next falling edge. DATA goes to DATA_ACK on the falling edge after eight bits. DATA_ACK goes back to DATA on the next falling edge.

Top module: `twi_rx_slave`

## Requirements
- R1: With ADDR_PINS=2, the own address is 010, then 11, then addr_pins_i[1:0], with bit 0 of the address byte equal to 0. That byte (0x5A when the pins are 01) is acknowledged by holding the data line low during the ninth clock.
- R2: With ADDR_PINS=4, the own address is 010 followed by addr_pins_i[3:0], with a write bit of 0. With pins 0110 the byte 0x4C is acknowledged.
- R3: An address byte that does not match, or that has bit 0 set to 1 (read), gets no acknowledge. No data byte is delivered or acknowledged after it until the next start.
- R4: start_o pulses for a start seen while the bus is free. rstart_o pulses for a start seen with no stop since the previous start. The two never pulse together.
- R5: stop_o pulses on a stop only if this device's address was matched since the last start.
- R6: Each data byte is assembled most significant bit first. byte_valid_o pulses once per complete data byte, with byte_o holding the value. byte_idx_o is 0 for the first byte after the address and counts up, holding at its all-ones value.
- R7: sda_oe_o rises only at the falling clock edge that begins a ninth clock and falls at the next falling clock edge, or at a start or stop. It stays low during the data bits.
- R8: A pulse on either line shorter than the filter length, which is derived from CLK_HZ and GLITCH_NS, creates no clock edge, start or stop.
- R9: A stop in the middle of a data byte delivers none of that byte, and stop_o still pulses.
- R10: During and straight after reset, sda_oe_o, byte_valid_o, start_o, rstart_o and stop_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | ADDR_PINS | Strap inputs giving the low address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| byte_valid_o | output | 1 | One-cycle strobe for a received data byte |
| byte_o | output | 8 | Received data byte |
| byte_idx_o | output | IDX_W | Position of the byte after the address, saturating |
| start_o | output | 1 | Pulse: start on a free bus |
| rstart_o | output | 1 | Pulse: repeated start |
| stop_o | output | 1 | Pulse: stop ending a transfer to this device |

## Verification
The assertions assume that the data line changes only while the clock line is low, apart from start and stop. They also assume that the clock and data lines are filtered with the same delay, so a filtered clock edge and a filtered data change keep their order. They further assume that the address straps are static. The stimulus drives every data change a full quarter bit after the clock falls, keeps each level far longer than the filter length, and holds the glitches it injects well below the filter length. This keeps the bus legal while still testing that short pulses are rejected.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_t;

    localparam logic [2:0] ADDR_PREFIX = 3'b010;
    localparam int         BYTE_BITS   = 8;

    // Clock cycles spanned by the glitch width, rounded up.
    function automatic int glitch_cycles(input int clk_hz, input int glitch_ns);
        return ((clk_hz / 1000) * glitch_ns + 999_999) / 1_000_000;
    endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int   FILT_LEN  = 8,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RESET_VAL}};
            run_q  <= '0;
            filt_q <= RESET_VAL;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == filt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    // Data moving while the clock is steadily high marks a bus condition.
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
    parameter int ADDR_PINS = 2
) (
    input  logic [ADDR_PINS-1:0] pins_i,
    input  logic [7:0]           rx_byte_i,
    output logic                 hit_o
);
    import twi_rx_pkg::*;

    logic [6:0] own_addr;

    generate
        if (ADDR_PINS == 2) begin : g_two_pin
            assign own_addr = {ADDR_PREFIX, 2'b11, pins_i};
        end else begin : g_four_pin
            assign own_addr = {ADDR_PREFIX, pins_i};
        end
    endgenerate

    // Upper seven bits are the address, bit 0 must request a write.
    assign hit_o = (rx_byte_i[7:1] == own_addr) && !rx_byte_i[0];
endmodule

// File: rtl/twi_rx_slave.sv
module twi_rx_slave #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int GLITCH_NS = 50,
    parameter int ADDR_PINS = 2,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [ADDR_PINS-1:0] addr_pins_i,
    output logic                 sda_oe_o,
    output logic                 byte_valid_o,
    output logic [7:0]           byte_o,
    output logic [IDX_W-1:0]     byte_idx_o,
    output logic                 start_o,
    output logic                 rstart_o,
    output logic                 stop_o
);
    import twi_rx_pkg::*;

    localparam int FILT_LEN = glitch_cycles(CLK_HZ, GLITCH_NS) + 1;
    localparam int CNT_W    = $clog2(BYTE_BITS + 1);

    // Line conditioning: index 0 is the clock line, index 1 the data line.
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            twi_glitch_filter #(
                .FILT_LEN (FILT_LEN),
                .RESET_VAL(1'b1)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .line_i(raw_lines[g]),
                .line_o(filt_lines[g])
            );
        end
    endgenerate

    logic scl_rise, scl_fall, start_det, stop_det;

    twi_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    logic [7:0]       shift_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             addr_hit;

    twi_addr_match #(
        .ADDR_PINS(ADDR_PINS)
    ) u_match (
        .pins_i   (addr_pins_i),
        .rx_byte_i(shift_q),
        .hit_o    (addr_hit)
    );

    rx_state_t        state_q, state_nx;
    logic             bus_busy_q;
    logic             addressed_q;
    logic [IDX_W-1:0] data_idx_q;
    logic             byte_done;

    assign byte_done = scl_fall && (bit_cnt_q == CNT_W'(BYTE_BITS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state_q;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                ST_ADDR: begin
                    if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_nx = ST_DATA;
                end
                ST_DATA: begin
                    if (byte_done) state_nx = ST_DATA_ACK;
                end
                ST_DATA_ACK: begin
                    if (scl_fall) state_nx = ST_DATA;
                end
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o     <= 1'b0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
            byte_idx_o   <= '0;
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            shift_q      <= '0;
            bit_cnt_q    <= '0;
            bus_busy_q   <= 1'b0;
            addressed_q  <= 1'b0;
            data_idx_q   <= '0;
        end else begin
            byte_valid_o <= 1'b0;
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            if (start_det) begin
                start_o     <= !bus_busy_q;
                rstart_o    <= bus_busy_q;
                bus_busy_q  <= 1'b1;
                addressed_q <= 1'b0;
                bit_cnt_q   <= '0;
                sda_oe_o    <= 1'b0;
            end else if (stop_det) begin
                stop_o      <= addressed_q;
                bus_busy_q  <= 1'b0;
                addressed_q <= 1'b0;
                bit_cnt_q   <= '0;
                sda_oe_o    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bit_cnt_q != CNT_W'(BYTE_BITS)) begin
                            shift_q   <= {shift_q[6:0], filt_lines[1]};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe_o    <= 1'b1;
                                    addressed_q <= 1'b1;
                                    data_idx_q  <= '0;
                                end
                            end else begin
                                sda_oe_o     <= 1'b1;
                                byte_valid_o <= 1'b1;
                                byte_o       <= shift_q;
                                byte_idx_o   <= data_idx_q;
                                if (data_idx_q != {IDX_W{1'b1}}) begin
                                    data_idx_q <= data_idx_q + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o  <= 1'b0;
                            bit_cnt_q <= '0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe_o <= 1'b0;
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_rx_slave_chk.sv
module twi_rx_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic addressed_q,
    input logic sda_oe_o,
    input logic byte_valid_o,
    input logic start_o,
    input logic rstart_o,
    input logic stop_o
);
    a_r4_start_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && rstart_o));

    a_r4_start_pulse_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || rstart_o) |-> $past(start_det));

    a_r5_stop_pulse_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(stop_det && addressed_q));

    a_r6_byte_on_clock_fall: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(scl_fall));

    a_r3_byte_needs_address: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(addressed_q));

    a_r7_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall));

    a_r7_ack_ends_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

    a_r10_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !(sda_oe_o || byte_valid_o || start_o || rstart_o || stop_o));
endmodule

bind twi_rx_slave twi_rx_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .addressed_q (addressed_q),
    .sda_oe_o    (sda_oe_o),
    .byte_valid_o(byte_valid_o),
    .start_o     (start_o),
    .rstart_o    (rstart_o),
    .stop_o      (stop_o)
);

// File: tb/twi_rx_slave_bench.sv
module twi_rx_slave_bench;
    localparam int Q = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_line;

    logic       oe_a, va, st_a, rs_a, sp_a;
    logic [7:0] by_a;
    logic [1:0] ix_a;
    logic       oe_b, vb, st_b, rs_b, sp_b;
    logic [7:0] by_b;
    logic [3:0] ix_b;

    assign sda_line = sda_m & ~oe_a & ~oe_b;

    twi_rx_slave #(.ADDR_PINS(2), .IDX_W(2)) u_twi_rx_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pins_i(2'b01), .sda_oe_o(oe_a), .byte_valid_o(va),
        .byte_o(by_a), .byte_idx_o(ix_a), .start_o(st_a),
        .rstart_o(rs_a), .stop_o(sp_a));

    twi_rx_slave #(.ADDR_PINS(4), .IDX_W(4)) u_twi_rx_slave_p4 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pins_i(4'b0110), .sda_oe_o(oe_b), .byte_valid_o(vb),
        .byte_o(by_b), .byte_idx_o(ix_b), .start_o(st_b),
        .rstart_o(rs_b), .stop_o(sp_b));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cs_a = 0, cr_a = 0, cp_a = 0, cs_b = 0, cr_b = 0, cp_b = 0;
    logic [15:0] qa[$];
    logic [15:0] qb[$];

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (va) begin
                if (qa.size() == 0) check("R6 unexpected byte on A", 1'b0, {6'd0, ix_a, by_a}, 0);
                else begin
                    logic [15:0] e;
                    e = qa.pop_front();
                    check("R6 byte/index on A", {6'd0, ix_a, by_a} == e, {6'd0, ix_a, by_a}, e);
                end
            end
            if (vb) begin
                if (qb.size() == 0) check("R6 unexpected byte on B", 1'b0, {4'd0, ix_b, by_b}, 0);
                else begin
                    logic [15:0] e;
                    e = qb.pop_front();
                    check("R6 byte/index on B", {4'd0, ix_b, by_b} == e, {4'd0, ix_b, by_b}, e);
                end
            end
            if (st_a) cs_a++;
            if (rs_a) cr_a++;
            if (sp_a) cp_a++;
            if (st_b) cs_b++;
            if (rs_b) cr_b++;
            if (sp_b) cp_b++;
        end
    end

    task automatic m_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic m_bit(input bit b, input bit glitch);
        tick(10);
        if (glitch) begin scl_m = 1'b1; tick(5); scl_m = 1'b0; end
        else tick(5);
        tick(Q - 15);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        tick(Q / 2);
        check("R7 no drive during data bit", sda_line == b, sda_line, b);
        if (glitch && b) begin sda_m = 1'b0; tick(5); sda_m = 1'b1; end
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic m_byte(input logic [7:0] b, input bit glitch, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) m_bit(b[i], glitch);
        sda_m = 1'b1;
        tick(Q);
        check({req, " ack after eighth fall"}, sda_line == !exp_ack, sda_line, !exp_ack);
        scl_m = 1'b1;
        tick(Q);
        check({req, " ack in ninth clock"}, sda_line == !exp_ack, sda_line, !exp_ack);
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
        check("R7 release after ninth clock", !(oe_a || oe_b), {oe_a, oe_b}, 0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 1'b0, 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s0, r0, p0, pb0, rb0;
        tick(5);
        // R10: reset state
        check("R10 outputs quiet in reset", {oe_a, va, st_a, rs_a, sp_a, oe_b, vb} == 0,
              {oe_a, va, st_a, rs_a, sp_a, oe_b, vb}, 0);
        rst_n = 1'b1;
        tick(20);
        check("R10 outputs quiet after reset", {oe_a, va, st_a, rs_a, sp_a, oe_b, vb} == 0,
              {oe_a, va, st_a, rs_a, sp_a, oe_b, vb}, 0);

        // R1, R4, R5, R6: plain write to A
        s0 = cs_a; p0 = cp_a; pb0 = cp_b;
        m_start();
        m_byte(8'h5A, 0, 1, "R1 two-pin address");
        qa.push_back({8'd0, 8'h00}); m_byte(8'h00, 0, 1, "R6 data");
        qa.push_back({8'd1, 8'hFF}); m_byte(8'hFF, 0, 1, "R6 data");
        qa.push_back({8'd2, 8'hA5}); m_byte(8'hA5, 0, 1, "R6 data");
        m_stop();
        check("R4 start pulse on free bus", cs_a == s0 + 1, cs_a - s0, 1);
        check("R5 stop pulse for addressed", cp_a == p0 + 1, cp_a - p0, 1);
        check("R5 no stop pulse when not addressed", cp_b == pb0, cp_b - pb0, 0);
        check("R6 all bytes delivered", qa.size() == 0, qa.size(), 0);

        // R3: read bit set
        p0 = cp_a;
        m_start();
        m_byte(8'h5B, 0, 0, "R3 read bit");
        m_byte(8'h33, 0, 0, "R3 ignored data");
        m_stop();
        check("R3 R5 no stop pulse after read request", cp_a == p0, cp_a - p0, 0);

        // R3: address mismatch
        m_start();
        m_byte(8'h5E, 0, 0, "R3 mismatch");
        m_byte(8'h44, 0, 0, "R3 ignored data");
        m_stop();
        check("R3 no stop pulse after mismatch", cp_a == p0, cp_a - p0, 0);

        // R2, R4: B then repeated start to A
        s0 = cs_a; r0 = cr_a; p0 = cp_a; pb0 = cp_b; rb0 = cr_b;
        m_start();
        m_byte(8'h4C, 0, 1, "R2 four-pin address");
        qb.push_back({8'd0, 8'h12}); m_byte(8'h12, 0, 1, "R2 data");
        m_start();
        m_byte(8'h5A, 0, 1, "R4 address after repeated start");
        qa.push_back({8'd0, 8'h34}); m_byte(8'h34, 0, 1, "R4 data");
        m_stop();
        check("R4 one start", cs_a == s0 + 1, cs_a - s0, 1);
        check("R4 repeated start on A", cr_a == r0 + 1, cr_a - r0, 1);
        check("R4 repeated start on B", cr_b == rb0 + 1, cr_b - rb0, 1);
        check("R5 stop on A", cp_a == p0 + 1, cp_a - p0, 1);
        check("R5 no stop on B", cp_b == pb0, cp_b - pb0, 0);
        check("R2 B byte delivered", qb.size() == 0, qb.size(), 0);

        // R6: index saturation (A has a two-bit index)
        m_start();
        m_byte(8'h5A, 0, 1, "R6 address");
        for (int i = 0; i < 5; i++) begin
            qa.push_back({8'((i > 3) ? 3 : i), 8'(i + 1)});
            m_byte(8'(i + 1), 0, 1, "R6 saturating index");
        end
        m_stop();
        check("R6 saturation bytes delivered", qa.size() == 0, qa.size(), 0);

        // R9: stop in the middle of a data byte
        p0 = cp_a;
        m_start();
        m_byte(8'h5A, 0, 1, "R9 address");
        qa.push_back({8'd0, 8'h11}); m_byte(8'h11, 0, 1, "R9 data");
        for (int i = 0; i < 4; i++) m_bit(1'b1, 0);
        m_stop();
        check("R9 partial byte dropped", qa.size() == 0, qa.size(), 0);
        check("R9 stop still pulses", cp_a == p0 + 1, cp_a - p0, 1);

        // R8: glitches on both lines
        s0 = cs_a; r0 = cr_a; p0 = cp_a;
        m_start();
        m_byte(8'h5A, 1, 1, "R8 glitched address");
        qa.push_back({8'd0, 8'hB7}); m_byte(8'hB7, 1, 1, "R8 glitched data");
        m_stop();
        check("R8 no spurious start", cs_a == s0 + 1, cs_a - s0, 1);
        check("R8 no spurious repeated start", cr_a == r0, cr_a - r0, 0);
        check("R8 one stop", cp_a == p0 + 1, cp_a - p0, 1);
        check("R8 byte intact", qa.size() == 0, qa.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule